// File: doc/BRIEF.md
# Hardware breakpoint debug unit

The unit watches every processor access (instruction fetch, data read, data write, I/O access) and compares its address and byte span against four programmable breakpoint addresses. Each breakpoint has a packed type field and a packed length field in a control register. Matching accesses raise a debug event one cycle later. Execution hits are signalled on the fault output, so the core can stop before the instruction retires. Data and I/O hits are signalled on the trap output, after the access has completed. A status register gathers the breakpoints and conditions behind each event. Single-step and task-switch conditions arrive as one-cycle strobes.

A privileged register port reaches the eight debug register indices. The port can be locked by a protection bit in the control register. A locked access is turned into a debug fault, and the protection bit is dropped so that the handler can reach the registers. Indices 4 and 5 alias the status and control registers, or raise an invalid-opcode indication, depending on the debugging-extensions mode input.

Top module: `dbg_unit`

## Requirements
- R1: After reset, all eight debug registers read as 0 and fault_o, trap_o, gp_fault_o, ud_fault_o and reg_rdata_o are 0.
- R2: A port request with reg_cpl_i != 0 pulses gp_fault_o in the next cycle, returns 0 on reg_rdata_o and changes no register. This check takes priority over the protection and invalid-index checks.
- R3: Port indices 0 to 3 are the breakpoint addresses, which are stored unaligned. Index 6 is the status register, in which only bits 0-3, 13, 14 and 15 hold a value and all other bits read 0. Index 7 is the control register. Read data appears on reg_rdata_o in the cycle after the request, and is 0 for writes.
- R4: With de_mode_i = 0, indices 4 and 5 reach the status and control registers. With de_mode_i = 1, a request to index 4 or 5 pulses ud_fault_o in the next cycle and has no effect.
- R5: While control bit 13 is set, any port access at privilege 0 is blocked. The access changes no register and returns 0. fault_o pulses in the next cycle, status bit 13 is set and control bit 13 is cleared.
- R6: Breakpoint n is armed by control bit 2n or 2n+1. Its type field is control[17+4n:16+4n]: 00 execute, 01 data write, 10 I/O read or write, 11 data read or write (never a fetch). acc_kind_i is encoded as 00 fetch, 01 read, 10 write, 11 I/O. An unarmed breakpoint never hits.
- R7: The length field is control[19+4n:18+4n]: 00 is 1 byte, 01 is 2 bytes, 11 is 4 bytes. The stored address has 1 or 2 low bits cleared according to the length. The access covers acc_addr_i to acc_addr_i + acc_len_i (acc_len_i = bytes - 1). A hit needs at least one common byte.
- R8: Three settings never hit: length 10; type 10 while de_mode_i = 0; and an execute type with a length other than 00.
- R9: An execution hit pulses fault_o in the cycle after the access. A data or I/O hit pulses trap_o in the cycle after the access. In both cases the status bits of the hitting breakpoints are set.
- R10: An access with resume_i = 1 produces no execution hit: no fault and no status bit.
- R11: step_i pulses trap_o in the next cycle and sets status bit 14. tswitch_i pulses fault_o in the next cycle and sets status bit 15.
- R12: All breakpoints that hit in one access set their status bits together. Status bits stay set until a port write to the status register.
- R13: A status write in the same cycle as a debug event stores the written value with the bits of the event added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| de_mode_i | input | 1 | Debugging-extensions mode |
| acc_valid_i | input | 1 | Processor access present this cycle |
| acc_kind_i | input | 2 | Access kind: 00 fetch, 01 read, 10 write, 11 I/O |
| acc_addr_i | input | 32 | Access start address |
| acc_len_i | input | 2 | Access size in bytes minus one |
| resume_i | input | 1 | Suppress execution hits for this access |
| step_i | input | 1 | Single-step condition strobe |
| tswitch_i | input | 1 | Task-switch condition strobe |
| reg_req_i | input | 1 | Register port request |
| reg_we_i | input | 1 | Register port write |
| reg_idx_i | input | 3 | Debug register index 0 to 7 |
| reg_wdata_i | input | 32 | Register port write data |
| reg_cpl_i | input | 2 | Current privilege level of the requester |
| reg_rdata_o | output | 32 | Read data, one cycle after the request |
| gp_fault_o | output | 1 | General-protection indication |
| ud_fault_o | output | 1 | Invalid-opcode indication |
| fault_o | output | 1 | Fault-class debug event |
| trap_o | output | 1 | Trap-class debug event |

## Verification
The status register has two writers that can act at the same edge: a port write that clears it, and a breakpoint hit that sets bits in it. The bench first loads an unrelated status bit through the port. In a single cycle it then issues a status write of zero together with a data write that two breakpoints cover. A later read must show exactly the two breakpoint bits: the earlier bit is gone and no hit bit is lost. The bench also checks ordering at the port, where an unprivileged access to a locked register file must report general protection and not a debug fault.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int IDX_W    = 3;
  localparam int IDX_STAT = 6;
  localparam int IDX_CTRL = 7;
  localparam int PROT_BIT = 13;
  localparam int STEP_BIT = 14;
  localparam int TSW_BIT  = 15;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_IO    = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    BT_EXEC = 2'b00,
    BT_WR   = 2'b01,
    BT_IO   = 2'b10,
    BT_RW   = 2'b11
  } bp_type_e;

  typedef enum logic [1:0] {
    BL_1   = 2'b00,
    BL_2   = 2'b01,
    BL_BAD = 2'b10,
    BL_4   = 2'b11
  } bp_len_e;
endpackage

// File: rtl/dbg_cmp.sv
module dbg_cmp
  import dbg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] bp_addr_i,
  input  logic              armed_i,
  input  logic [1:0]        bp_type_i,
  input  logic [1:0]        bp_len_i,
  input  logic              de_mode_i,
  input  logic              acc_valid_i,
  input  logic [1:0]        acc_kind_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_len_i,
  output logic              exec_hit_o,
  output logic              data_hit_o
);
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W:0]   base, last, a_lo, a_hi;
  logic              len_ok, overlap, kind_ok, live;

  always_comb begin
    len_ok = 1'b1;
    unique case (bp_len_i)
      BL_1:    mask = '1;
      BL_2:    mask = {{(ADDR_W-1){1'b1}}, 1'b0};
      BL_4:    mask = {{(ADDR_W-2){1'b1}}, 2'b00};
      default: begin mask = '1; len_ok = 1'b0; end
    endcase
  end

  assign base    = {1'b0, bp_addr_i & mask};
  assign last    = {1'b0, (bp_addr_i & mask) | ~mask};
  assign a_lo    = {1'b0, acc_addr_i};
  assign a_hi    = a_lo + (ADDR_W+1)'(acc_len_i);
  assign overlap = (a_lo <= last) && (a_hi >= base);
  assign live    = acc_valid_i && armed_i && len_ok && overlap;

  always_comb begin
    unique case (bp_type_i)
      BT_WR:   kind_ok = (acc_kind_i == ACC_WRITE);
      BT_IO:   kind_ok = de_mode_i && (acc_kind_i == ACC_IO);
      BT_RW:   kind_ok = (acc_kind_i == ACC_READ) || (acc_kind_i == ACC_WRITE);
      default: kind_ok = 1'b0;
    endcase
  end

  // execute type: fetches only, and only with 1-byte length
  assign exec_hit_o = live && (bp_type_i == BT_EXEC) && (bp_len_i == BL_1)
                      && (acc_kind_i == ACC_FETCH);
  assign data_hit_o = live && kind_ok;
endmodule

// File: rtl/dbg_regs.sv
module dbg_regs
  import dbg_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int ADDR_W = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          de_mode_i,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [ADDR_W-1:0]             wdata_i,
  input  logic [1:0]                    cpl_i,
  input  logic [ADDR_W-1:0]             stat_set_i,
  output logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr_o,
  output logic [ADDR_W-1:0]             ctrl_o,
  output logic [ADDR_W-1:0]             rdata_o,
  output logic                          gp_o,
  output logic                          ud_o,
  output logic                          prot_o
);
  localparam logic [ADDR_W-1:0] STAT_MASK =
      ADDR_W'((1 << NUM_BP) - 1) | ADDR_W'(32'h0000_E000);

  logic [ADDR_W-1:0] ctrl_q, status_q, rd_d;
  logic [IDX_W-1:0]  eff_idx;
  logic              gp, prot, ud, ok, wr_ok, stat_wr, ctrl_wr;

  // priority: privilege, then protection, then invalid index
  assign gp      = req_i && (cpl_i != 2'd0);
  assign prot    = req_i && !gp && ctrl_q[PROT_BIT];
  assign ud      = req_i && !gp && !prot && de_mode_i && (idx_i == 3'd4 || idx_i == 3'd5);
  assign ok      = req_i && !gp && !prot && !ud;
  assign wr_ok   = ok && we_i;
  assign eff_idx = (idx_i == 3'd4 || idx_i == 3'd5) ? (idx_i + 3'd2) : idx_i;
  assign stat_wr = wr_ok && (eff_idx == IDX_W'(IDX_STAT));
  assign ctrl_wr = wr_ok && (eff_idx == IDX_W'(IDX_CTRL));

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bp_addr_o[g] <= '0;
      else if (wr_ok && eff_idx == IDX_W'(g)) bp_addr_o[g] <= wdata_i;
    end
  end

  always_comb begin
    rd_d = '0;
    if (ok && !we_i) begin
      if (eff_idx == IDX_W'(IDX_STAT)) rd_d = status_q;
      else if (eff_idx == IDX_W'(IDX_CTRL)) rd_d = ctrl_q;
      else begin
        for (int i = 0; i < NUM_BP; i++)
          if (eff_idx == IDX_W'(i)) rd_d = bp_addr_o[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      status_q <= '0;
      rdata_o  <= '0;
      gp_o     <= 1'b0;
      ud_o     <= 1'b0;
      prot_o   <= 1'b0;
    end else begin
      if (prot) ctrl_q[PROT_BIT] <= 1'b0;
      else if (ctrl_wr) ctrl_q <= wdata_i;
      // event bits are added on top of a same-cycle write
      status_q <= ((stat_wr ? wdata_i : status_q) | stat_set_i
                   | (ADDR_W'(prot) << PROT_BIT)) & STAT_MASK;
      rdata_o  <= rd_d;
      gp_o     <= gp;
      ud_o     <= ud;
      prot_o   <= prot;
    end
  end

  assign ctrl_o = ctrl_q;

  // R2
  gp_keeps_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gp |=> $stable(ctrl_q));

  // R12
  stat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R5
  prot_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot |=> (!ctrl_q[PROT_BIT] && status_q[PROT_BIT]));
endmodule

// File: rtl/dbg_unit.sv
module dbg_unit
  import dbg_pkg::*;
#(
  parameter int NUM_BP = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              de_mode_i,
  input  logic              acc_valid_i,
  input  logic [1:0]        acc_kind_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_len_i,
  input  logic              resume_i,
  input  logic              step_i,
  input  logic              tswitch_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_idx_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic [1:0]        reg_cpl_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic              gp_fault_o,
  output logic              ud_fault_o,
  output logic              fault_o,
  output logic              trap_o
);
  logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr;
  logic [ADDR_W-1:0]             ctrl, stat_set;
  logic [NUM_BP-1:0]             exec_hit, data_hit, exec_live;
  logic                          prot_q, fault_q, trap_q;
  logic                          unused_ctrl;

  dbg_regs #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .de_mode_i  (de_mode_i),
    .req_i      (reg_req_i),
    .we_i       (reg_we_i),
    .idx_i      (reg_idx_i),
    .wdata_i    (reg_wdata_i),
    .cpl_i      (reg_cpl_i),
    .stat_set_i (stat_set),
    .bp_addr_o  (bp_addr),
    .ctrl_o     (ctrl),
    .rdata_o    (reg_rdata_o),
    .gp_o       (gp_fault_o),
    .ud_o       (ud_fault_o),
    .prot_o     (prot_q)
  );

  for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
    dbg_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .bp_addr_i   (bp_addr[g]),
      .armed_i     (ctrl[2*g] | ctrl[2*g+1]),
      .bp_type_i   (ctrl[16+4*g +: 2]),
      .bp_len_i    (ctrl[18+4*g +: 2]),
      .de_mode_i   (de_mode_i),
      .acc_valid_i (acc_valid_i),
      .acc_kind_i  (acc_kind_i),
      .acc_addr_i  (acc_addr_i),
      .acc_len_i   (acc_len_i),
      .exec_hit_o  (exec_hit[g]),
      .data_hit_o  (data_hit[g])
    );
  end

  assign exec_live = resume_i ? '0 : exec_hit;

  always_comb begin
    stat_set = '0;
    stat_set[NUM_BP-1:0] = exec_live | data_hit;
    stat_set[STEP_BIT]   = step_i;
    stat_set[TSW_BIT]    = tswitch_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      fault_q <= (|exec_live) | tswitch_i;
      trap_q  <= (|data_hit) | step_i;
    end
  end

  assign fault_o     = fault_q | prot_q;
  assign trap_o      = trap_q;
  assign unused_ctrl = ^ctrl;

  // R9
  fault_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(acc_valid_i || tswitch_i || reg_req_i));

  // R9
  trap_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(acc_valid_i || step_i));

  // R10
  resume_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && resume_i && acc_kind_i == ACC_FETCH && !tswitch_i && !reg_req_i)
    |=> !fault_o);

  // R4
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({gp_fault_o, ud_fault_o}));
endmodule

// File: tb/dbg_unit_test.sv
module dbg_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        de_mode = 1'b0, acc_valid = 1'b0, resume = 1'b0, step = 1'b0, tsw = 1'b0;
  logic [1:0]  acc_kind = '0, acc_len = '0, cpl = '0;
  logic [31:0] acc_addr = '0, wdata = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  idx = '0;
  logic [31:0] rdata;
  logic        gp, ud, fault, trap;

  dbg_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .de_mode_i(de_mode),
    .acc_valid_i(acc_valid), .acc_kind_i(acc_kind), .acc_addr_i(acc_addr),
    .acc_len_i(acc_len), .resume_i(resume), .step_i(step), .tswitch_i(tsw),
    .reg_req_i(req), .reg_we_i(we), .reg_idx_i(idx), .reg_wdata_i(wdata),
    .reg_cpl_i(cpl), .reg_rdata_o(rdata), .gp_fault_o(gp), .ud_fault_o(ud),
    .fault_o(fault), .trap_o(trap)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    logic        f, t, g, u;
    logic [31:0] rd;
    string       rq;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  logic de_m = 1'b0;
  logic done = 1'b0;

  localparam logic [1:0] K_F = 2'b00, K_R = 2'b01, K_W = 2'b10, K_IO = 2'b11;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  initial begin
    forever begin
      @(posedge clk); #2;
      while (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if ({fault, trap, gp, ud} !== {e.f, e.t, e.g, e.u} || rdata !== e.rd) begin
          n_fail++;
          $display("FAIL %s: f/t/gp/ud=%b%b%b%b rd=%h expected %b%b%b%b rd=%h",
                   e.rq, fault, trap, gp, ud, rdata, e.f, e.t, e.g, e.u, e.rd);
        end
      end
    end
  end

  task automatic op(input logic av, input logic [1:0] k, input logic [31:0] a,
                    input logic [1:0] l, input logic res, input logic stp, input logic ts,
                    input logic rq_, input logic we_, input logic [2:0] ix,
                    input logic [31:0] wd, input logic [1:0] pl,
                    input logic ef, input logic et, input logic eg, input logic eu,
                    input logic [31:0] erd, input string r);
    exp_t e;
    @(posedge clk); #1;
    de_mode = de_m; acc_valid = av; acc_kind = k; acc_addr = a; acc_len = l;
    resume = res; step = stp; tsw = ts; req = rq_; we = we_; idx = ix;
    wdata = wd; cpl = pl;
    e.due = cyc + 1; e.f = ef; e.t = et; e.g = eg; e.u = eu; e.rd = erd; e.rq = r;
    q.push_back(e);
  endtask

  task automatic acc(input logic [1:0] k, input logic [31:0] a, input logic [1:0] l,
                     input logic res, input logic ef, input logic et, input string r);
    op(1, k, a, l, res, 0, 0, 0, 0, 0, 0, 0, ef, et, 0, 0, 0, r);
  endtask

  task automatic rd(input logic [2:0] ix, input logic [1:0] pl, input logic [31:0] erd,
                    input logic ef, input logic eg, input logic eu, input string r);
    op(0, 0, 0, 0, 0, 0, 0, 1, 0, ix, 0, pl, ef, 0, eg, eu, erd, r);
  endtask

  task automatic wr(input logic [2:0] ix, input logic [31:0] wd, input logic [1:0] pl,
                    input logic ef, input logic eg, input logic eu, input string r);
    op(0, 0, 0, 0, 0, 0, 0, 1, 1, ix, wd, pl, ef, 0, eg, eu, 0, r);
  endtask

  task automatic idle();
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  // watchdog
  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: timeout actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    n_chk++;
    if ({fault, trap, gp, ud} !== 4'b0 || rdata !== 32'h0) begin
      n_fail++;
      $display("FAIL R1 reset outputs: %b%b%b%b rd=%h expected 0000 rd=0",
               fault, trap, gp, ud, rdata);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1 reset contents
    rd(6, 0, 32'h0, 0, 0, 0, "R1 status");
    rd(7, 0, 32'h0, 0, 0, 0, "R1 ctrl");
    rd(0, 0, 32'h0, 0, 0, 0, "R1 bp0");
    // R2 privilege
    wr(0, 32'h1000, 3, 0, 1, 0, "R2 gp on write");
    rd(0, 0, 32'h0, 0, 0, 0, "R2 no change");
    rd(7, 1, 32'h0, 0, 1, 0, "R2 gp on read");
    // setup
    wr(0, 32'h0000_1000, 0, 0, 0, 0, "R3 wr bp0");
    wr(1, 32'h0000_2002, 0, 0, 0, 0, "R3 wr bp1");
    wr(2, 32'h0000_3005, 0, 0, 0, 0, "R3 wr bp2");
    wr(3, 32'h0000_0040, 0, 0, 0, 0, "R3 wr bp3");
    wr(7, 32'h2F50_0099, 0, 0, 0, 0, "R3 wr ctrl");
    rd(7, 0, 32'h2F50_0099, 0, 0, 0, "R3 ctrl readback");
    rd(2, 0, 32'h0000_3005, 0, 0, 0, "R3 unaligned stored");
    // R9 exec fault
    acc(K_F, 32'h1000, 0, 0, 1, 0, "R9 exec fault");
    rd(6, 0, 32'h1, 0, 0, 0, "R9 status bit0");
    wr(6, 0, 0, 0, 0, 0, "R12 clear");
    // R10 resume
    acc(K_F, 32'h1000, 0, 1, 0, 0, "R10 resume no fault");
    rd(6, 0, 32'h0, 0, 0, 0, "R10 no status");
    // R6 / R7 matching
    acc(K_R, 32'h1000, 0, 0, 0, 0, "R6 exec type ignores read");
    acc(K_W, 32'h2003, 0, 0, 0, 1, "R7 2-byte range top");
    acc(K_W, 32'h2001, 0, 0, 0, 0, "R7 below range");
    acc(K_W, 32'h2000, 3, 0, 0, 1, "R7 wide access overlap");
    acc(K_R, 32'h2002, 0, 0, 0, 0, "R6 write type ignores read");
    acc(K_R, 32'h3007, 0, 0, 0, 1, "R7 4-byte aligned range");
    acc(K_W, 32'h3002, 1, 0, 0, 0, "R7 adjacent no overlap");
    acc(K_W, 32'h3003, 1, 0, 0, 1, "R7 straddle overlap");
    acc(K_F, 32'h3004, 0, 0, 0, 0, "R6 rw type ignores fetch");
    rd(6, 0, 32'h6, 0, 0, 0, "R12 sticky bits 1,2");
    wr(6, 0, 0, 0, 0, 0, "R12 clear");
    // R8 / R6 I/O
    acc(K_IO, 32'h40, 0, 0, 0, 0, "R8 io type de off");
    rd(6, 0, 32'h0, 0, 0, 0, "R8 io no status");
    de_m = 1'b1;
    acc(K_IO, 32'h40, 0, 0, 0, 1, "R6 io hit de on");
    rd(6, 0, 32'h8, 0, 0, 0, "R6 io status bit3");
    wr(6, 0, 0, 0, 0, 0, "R12 clear");
    // R4 aliasing
    rd(4, 0, 32'h0, 0, 0, 1, "R4 ud idx4");
    wr(5, 32'h0, 0, 0, 0, 1, "R4 ud idx5 write");
    rd(7, 0, 32'h2F50_0099, 0, 0, 0, "R4 ud no effect");
    de_m = 1'b0;
    rd(5, 0, 32'h2F50_0099, 0, 0, 0, "R4 idx5 alias ctrl");
    wr(4, 32'hFFFF_FFFF, 0, 0, 0, 0, "R4 idx4 alias write");
    rd(6, 0, 32'h0000_E00F, 0, 0, 0, "R3 status mask");
    rd(4, 0, 32'h0000_E00F, 0, 0, 0, "R4 idx4 alias read");
    wr(6, 0, 0, 0, 0, 0, "R12 clear");
    // R12 multi hit
    wr(2, 32'h0000_2000, 0, 0, 0, 0, "R12 move bp2");
    acc(K_W, 32'h2002, 0, 0, 0, 1, "R12 double hit trap");
    rd(6, 0, 32'h6, 0, 0, 0, "R12 both bits");
    // R13 same cycle write and hit
    wr(6, 32'h0000_4000, 0, 0, 0, 0, "R13 preload");
    op(1, K_W, 32'h2003, 0, 0, 0, 0, 1, 1, 6, 32'h0, 0, 0, 1, 0, 0, 0, "R13 write+hit");
    rd(6, 0, 32'h6, 0, 0, 0, "R13 merged status");
    wr(6, 0, 0, 0, 0, 0, "R12 clear");
    // R11 strobes
    op(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R11 step trap");
    op(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R11 tswitch fault");
    rd(6, 0, 32'h0000_C000, 0, 0, 0, "R11 status 14,15");
    wr(6, 0, 0, 0, 0, 0, "R12 clear");
    // R8 undefined lengths, R6 disarm
    wr(7, 32'h2F94_0089, 0, 0, 0, 0, "R8 ctrl bad lens");
    acc(K_F, 32'h1000, 0, 0, 0, 0, "R8 exec len nonzero");
    acc(K_W, 32'h2003, 0, 0, 0, 0, "R8 len 10 and disarmed");
    acc(K_R, 32'h2000, 0, 0, 0, 0, "R6 disarmed bp2");
    rd(6, 0, 32'h0, 0, 0, 0, "R8 no status");
    // R5 protection
    wr(7, 32'h0000_2000, 0, 0, 0, 0, "R5 lock");
    rd(0, 3, 32'h0, 0, 1, 0, "R2 gp before protection");
    wr(0, 32'h0000_BEEF, 0, 1, 0, 0, "R5 blocked write fault");
    rd(0, 0, 32'h0000_1000, 0, 0, 0, "R5 bp0 unchanged");
    rd(7, 0, 32'h0, 0, 0, 0, "R5 lock cleared");
    rd(6, 0, 32'h0000_2000, 0, 0, 0, "R5 status bit13");
    idle();
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule